// File: doc/BRIEF.md
# Shared Video RAM Address Multiplexer

This block forms the address path of a video board whose dynamic RAM is shared by a CRT controller and the host CPU. The bus clock phase divides each cycle into two halves. While the phase is low, the RAM address comes from the CRT controller's memory address, so that the board can fetch display data. While the phase is high, the CPU address passes straight through, so that the CPU can reach the same memory. The low bits of the RAM address always follow the scanning address during video fetches. Because those bits form the DRAM row address, normal display scanning also keeps the memory refreshed.

A write-only control register sits at a fixed I/O address, eight bytes above the CRT controller base. It supplies the two top RAM address bits that the controller cannot produce. It also selects one of four character sets in a glyph ROM that the CPU cannot read, and it can invert the horizontal and vertical sync signals, each on its own. One further bit enables a bitmap mode. In that mode the controller's two lowest character-row lines become RAM address bits 13:12 and no longer select a glyph line. This gives a pixel-addressable display even though the controller has a limit on its row count. In text mode, the glyph ROM address is built from the fetched character code, the character-set bits and the four low row lines.

Top module: `vram_addr_mux`

## Requirements
- R1: With `phi2` high, `ram_addr` equals `cpu_addr` and `cpu_slot` is 1. With `phi2` low, `ram_addr` carries the video address and `cpu_slot` is 0.
- R2: In text mode (control bit 6 clear), the video address is `{bank, crt_ma[13:0]}`, where `bank` is control bits 1:0.
- R3: In bitmap mode (control bit 6 set), the video address is `{bank, crt_ra[1:0], crt_ma[11:0]}`.
- R4: In the video phase, `ram_addr[7:0]` equals `crt_ma[7:0]` in both modes.
- R5: The control register is written at the rising clock edge when `phi2` is high, `cpu_rw` is 0 (write) and `cpu_addr` equals the CRT base (0xE880) plus 8. Bits 7 of the written byte is ignored. The bit layout is:
  - bits 1:0 are `bank`
  - bits 3:2 are the character set
  - bit 4 inverts horizontal sync
  - bit 5 inverts vertical sync
  - bit 6 enables bitmap mode
- R6: After reset the control register holds zero. This gives text mode, bank 0, character set 0 and syncs that pass through unchanged.
- R7: The following leave the control register unchanged:
  - a read (`cpu_rw` 1) at the control address
  - a write to any other address
  - a write while `phi2` is low
- R8: `hsync_out` is `hsync_in` XOR control bit 4, and `vsync_out` is `vsync_in` XOR control bit 5. Each inversion acts on its own sync signal only.
- R9: `charset` equals control bits 3:2. In text mode, `glyph_addr` is `{charset, char_code, crt_ra[3:0]}`. In bitmap mode, its four row bits are zero.
- R10: A control write takes effect only after its clock edge. During the write cycle, `ram_addr` carries the CPU address and all control-derived outputs still show the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock that samples control writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | Bus phase: 1 gives the CPU slot, 0 gives the video slot |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| crt_ma | input | 14 | CRT controller memory address |
| crt_ra | input | 5 | CRT controller character-row address |
| char_code | input | 8 | Character code fetched from RAM |
| hsync_in | input | 1 | Horizontal sync from the controller |
| vsync_in | input | 1 | Vertical sync from the controller |
| ram_addr | output | 16 | Multiplexed RAM address |
| cpu_slot | output | 1 | 1 while the RAM serves the CPU |
| charset | output | 2 | Selected character set |
| glyph_addr | output | 14 | Glyph ROM address |
| hsync_out | output | 1 | Horizontal sync after polarity adjustment |
| vsync_out | output | 1 | Vertical sync after polarity adjustment |

## Verification
A CPU write to the control register always falls in a CPU slot. In the same cycle, the video-side outputs (sync polarity, character set, glyph address) keep being driven from the register's current value. The bench provokes this overlap by presenting the write with distinct new data and checking two things before the capturing edge: `ram_addr` must still carry the CPU address, and every control-derived output must still show the old value. After the edge it checks that the new value has taken over. Sweeping every 7-bit control value, with address, row and sync patterns computed arithmetically, then judges both address modes, the refresh bits and the polarity logic against each setting.

// File: rtl/vram_addr_mux.sv
module vram_addr_mux #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int RA_W = 5,
  parameter int CODE_W = 8,
  parameter int ROW_W = 4,
  parameter logic [15:0] CRTC_BASE = 16'hE880,
  parameter int CTRL_OFS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       phi2,
  input  logic [AW-1:0]              cpu_addr,
  input  logic [DW-1:0]              cpu_data,
  input  logic                       cpu_rw,
  input  logic [AW-3:0]              crt_ma,
  input  logic [RA_W-1:0]            crt_ra,
  input  logic [CODE_W-1:0]          char_code,
  input  logic                       hsync_in,
  input  logic                       vsync_in,
  output logic [AW-1:0]              ram_addr,
  output logic                       cpu_slot,
  output logic [1:0]                 charset,
  output logic [2+CODE_W+ROW_W-1:0]  glyph_addr,
  output logic                       hsync_out,
  output logic                       vsync_out
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(CRTC_BASE) + AW'(CTRL_OFS);
  localparam int CTRL_W = 7;
  localparam int LOW_W = AW - 4;

  logic [CTRL_W-1:0] ctrl;
  logic              ctrl_wr;
  logic [1:0]        bank;
  logic              hires;
  logic [AW-1:0]     vid_addr;
  logic [ROW_W-1:0]  glyph_row;

  assign ctrl_wr = phi2 && !cpu_rw && (cpu_addr == CTRL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else if (ctrl_wr) ctrl <= cpu_data[CTRL_W-1:0];
  end

  assign bank    = ctrl[1:0];
  assign charset = ctrl[3:2];
  assign hires   = ctrl[6];

  assign vid_addr = hires ? {bank, crt_ra[1:0], crt_ma[LOW_W-1:0]}
                          : {bank, crt_ma};

  assign cpu_slot = phi2;
  assign ram_addr = phi2 ? cpu_addr : vid_addr;

  assign glyph_row  = hires ? '0 : crt_ra[ROW_W-1:0];
  assign glyph_addr = {charset, char_code, glyph_row};

  assign hsync_out = hsync_in ^ ctrl[4];
  assign vsync_out = vsync_in ^ ctrl[5];
endmodule

module vram_addr_mux_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int RA_W = 5,
  parameter int CODE_W = 8,
  parameter int ROW_W = 4,
  parameter logic [15:0] CRTC_BASE = 16'hE880,
  parameter int CTRL_OFS = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      phi2,
  input logic [AW-1:0]             cpu_addr,
  input logic [DW-1:0]             cpu_data,
  input logic                      cpu_rw,
  input logic [AW-3:0]             crt_ma,
  input logic [AW-1:0]             ram_addr,
  input logic                      cpu_slot,
  input logic [1:0]                charset,
  input logic                      hsync_in,
  input logic                      vsync_in,
  input logic                      hsync_out,
  input logic                      vsync_out
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(CRTC_BASE) + AW'(CTRL_OFS);

  assert_cpu_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phi2 |-> (ram_addr == cpu_addr) && cpu_slot);

  assert_video_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !phi2 |-> !cpu_slot);

  assert_refresh_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !phi2 |-> ram_addr[7:0] == crt_ma[7:0]);

  assert_ctrl_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phi2 && !cpu_rw && cpu_addr == CTRL_ADDR) |=>
      (charset == $past(cpu_data[3:2])) && ((hsync_out ^ hsync_in) == $past(cpu_data[4]))
      && ((vsync_out ^ vsync_in) == $past(cpu_data[5])));

  assert_ctrl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi2 && !cpu_rw && cpu_addr == CTRL_ADDR) |=>
      $stable(charset) && $stable(hsync_out ^ hsync_in) && $stable(vsync_out ^ vsync_in));
endmodule

bind vram_addr_mux vram_addr_mux_chk #(
  .AW(AW), .DW(DW), .RA_W(RA_W), .CODE_W(CODE_W), .ROW_W(ROW_W),
  .CRTC_BASE(CRTC_BASE), .CTRL_OFS(CTRL_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .phi2(phi2), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
  .cpu_rw(cpu_rw), .crt_ma(crt_ma), .ram_addr(ram_addr), .cpu_slot(cpu_slot),
  .charset(charset), .hsync_in(hsync_in), .vsync_in(vsync_in),
  .hsync_out(hsync_out), .vsync_out(vsync_out)
);

// File: tb/tb_vram_addr_mux.sv
module tb_vram_addr_mux;
  localparam int CLK_PERIOD = 10;
  localparam int CTRL = 16'hE888;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        phi2 = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_rw = 1;
  logic [13:0] crt_ma = '0;
  logic [4:0]  crt_ra = '0;
  logic [7:0]  char_code = '0;
  logic        hsync_in = 0, vsync_in = 0;
  logic [15:0] ram_addr;
  logic        cpu_slot;
  logic [1:0]  charset;
  logic [13:0] glyph_addr;
  logic        hsync_out, vsync_out;

  int checks = 0;
  int errors = 0;

  vram_addr_mux dut (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_rw(cpu_rw), .crt_ma(crt_ma), .crt_ra(crt_ra), .char_code(char_code),
    .hsync_in(hsync_in), .vsync_in(vsync_in), .ram_addr(ram_addr), .cpu_slot(cpu_slot),
    .charset(charset), .glyph_addr(glyph_addr), .hsync_out(hsync_out), .vsync_out(vsync_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic int exp_vid(int c, int ma, int ra);
    int bank = c & 3;
    if ((c >> 6) & 1) return bank * 16384 + (ra & 3) * 4096 + (ma % 4096);
    return bank * 16384 + ma;
  endfunction

  function automatic int exp_glyph(int c, int code, int ra);
    int row = ((c >> 6) & 1) ? 0 : (ra & 15);
    return ((c >> 2) & 3) * 4096 + code * 16 + row;
  endfunction

  task automatic bus_write(int addr, int data, bit rw, bit ph);
    @(negedge clk);
    cpu_addr = 16'(addr); cpu_data = 8'(data); cpu_rw = rw; phi2 = ph;
    @(posedge clk); #1;
    phi2 = 0; cpu_rw = 1;
  endtask

  task automatic check_state(string req, int c);
    check(req, charset, (c >> 2) & 3);
    hsync_in = 0; vsync_in = 0; #1;
    check(req, hsync_out, (c >> 4) & 1);
    check(req, vsync_out, (c >> 5) & 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    #(CLK_PERIOD * 3);
    // R6: reset state
    crt_ma = 14'h3ABC; crt_ra = 5'h1D; char_code = 8'h5A; #1;
    check("R6", ram_addr, exp_vid(0, 14'h3ABC, 5'h1D));
    check("R6", glyph_addr, exp_glyph(0, 8'h5A, 5'h1D));
    check_state("R6", 0);
    @(negedge clk); rst_n = 1;

    for (int c = 0; c < 128; c++) begin
      bus_write(CTRL, c | ((c & 1) << 7), 0, 1);
      check_state("R5", c);
      for (int k = 0; k < 6; k++) begin
        int ma = (c * 397 + k * 2731) % 16384;
        int ra = (c + k * 7) % 32;
        crt_ma = 14'(ma); crt_ra = 5'(ra); char_code = 8'(c * 3 + k);
        phi2 = 0; #1;
        check(((c >> 6) & 1) ? "R3" : "R2", ram_addr, exp_vid(c, ma, ra));
        check("R4", ram_addr & 255, ma & 255);
        check("R1", cpu_slot, 0);
        check("R9", glyph_addr, exp_glyph(c, (c * 3 + k) & 255, ra));
        cpu_addr = 16'((ma * 5 + 4660) % 65536); phi2 = 1; #1;
        check("R1", ram_addr, (ma * 5 + 4660) % 65536);
        check("R1", cpu_slot, 1);
        phi2 = 0;
      end
      for (int s = 0; s < 4; s++) begin
        hsync_in = s[0]; vsync_in = s[1]; #1;
        check("R8", hsync_out, s[0] ^ ((c >> 4) & 1));
        check("R8", vsync_out, s[1] ^ ((c >> 5) & 1));
      end
    end

    // R7: ignored accesses, control currently 0x7F
    bus_write(CTRL, 8'h00, 1, 1);
    check_state("R7", 127);
    bus_write(CTRL, 8'h00, 0, 0);
    check_state("R7", 127);
    bus_write(CTRL + 1, 8'h00, 0, 1);
    check_state("R7", 127);
    bus_write(CTRL - 8, 8'h00, 0, 1);
    check_state("R7", 127);

    // R10: write cycle overlaps video outputs; old value visible before edge
    bus_write(CTRL, 8'h2D, 0, 1);
    @(negedge clk);
    cpu_addr = 16'(CTRL); cpu_data = 8'h52; cpu_rw = 0; phi2 = 1;
    crt_ma = 14'h1234; crt_ra = 5'h06; char_code = 8'hC3; hsync_in = 0; vsync_in = 0; #1;
    check("R10", ram_addr, CTRL);
    check("R10", charset, 3);
    check("R10", hsync_out, 0);
    check("R10", vsync_out, 1);
    check("R10", glyph_addr, exp_glyph(8'h2D, 8'hC3, 6));
    @(posedge clk); #1;
    phi2 = 0; cpu_rw = 1; #1;
    check("R10", charset, 0);
    check("R10", hsync_out, 1);
    check("R10", vsync_out, 0);
    check("R10", ram_addr, exp_vid(8'h52, 14'h1234, 6));
    check("R10", glyph_addr, exp_glyph(8'h52, 8'hC3, 6));

    summary();
  end
endmodule